// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns one request at a time into a single timed cycle on an 8-bit NAND flash bus: a command latch, an address latch, a data write or a data read. A requester presents a cycle kind, a byte and a bank number with a valid strobe. The sequencer takes the request when idle, plays out the cycle phase by phase, and answers with a one-cycle acknowledge. Everything runs in one system clock domain.

Each phase has its own programmable length, given as a field on dedicated timing inputs. The fields use different encodings. Setup, strobe and hold fields count N+1 cycles. The turnaround (Hi-Z) field counts exactly N cycles. Two short 4-bit fields set the minimum delay from a command or address latch to the next read strobe. An active-low wait input from the flash stretches the strobe phase. The byte seen on the bus at the end of a read strobe is kept on a separate output.

Top module: `nand_cycle_seq`

## Requirements
- R1: The kind code selects the cycle: 0 = command (CLE high for the whole cycle), 1 = address (ALE high for the whole cycle), 2 = read (RE_n low in the strobe phase), 3 = write (WE_n low in the strobe phase). Command and address cycles also pulse WE_n low. RE_n and WE_n are never low together.
- R2: The setup phase comes first and lasts setup+1 cycles, with CE_n, CLE/ALE and the data bus already in their cycle state before the strobe falls.
- R3: For a write only, a turnaround of exactly hiz cycles follows setup, with the data output enable low. A hiz value of 0 adds no cycle. Command, address and read cycles ignore the field.
- R4: The strobe stays low for wait+1 cycles when the wait input is high. A field of 255 gives 256 cycles.
- R5: While wait_n is low the strobe phase is extended. The strobe rises only at a clock edge where wait_n is high and the programmed count has run out.
- R6: After the strobe rises, CE_n, CLE/ALE and the data output stay unchanged for hold+1 cycles. req_ack is then high for exactly one cycle, and busy falls on the next cycle.
- R7: A read that directly follows a command cycle has a setup phase of max(setup, cle_re)+1 cycles. A read that follows an address cycle uses max(setup, ale_re)+1. Any other read uses setup+1.
- R8: At the clock edge where RE_n rises, the byte on the data input is captured into rd_byte. rd_byte then holds that value until the next read.
- R9: During a cycle only ce_n[bank] is low. While idle, all chip enables are high.
- R10: The kind, byte, bank and all timing fields are taken at the accepting edge. Changing them during a cycle has no effect. A request raised while busy is never accepted.
- R11: After reset: busy and req_ack are 0, CLE, ALE and the output enable are 0, RE_n, WE_n and every CE_n are 1, and rd_byte is 0.
- R12: The data output shows the request byte whenever the output enable is high. The enable is high from the start of setup through hold for command and address cycles, and from the strobe through hold for writes. It is never high during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_kind | input | 2 | Cycle kind: 0 command, 1 address, 2 read, 3 write |
| req_byte | input | 8 | Byte for command, address or write |
| req_bank | input | 2 | Bank whose chip enable is driven |
| tim_setup | input | 8 | Setup length, N+1 cycles |
| tim_hiz | input | 8 | Write turnaround length, N cycles |
| tim_wait | input | 8 | Strobe length, N+1 cycles |
| tim_hold | input | 8 | Hold length, N+1 cycles |
| tim_cle_re | input | 4 | Minimum command-to-read setup, N+1 cycles |
| tim_ale_re | input | 4 | Minimum address-to-read setup, N+1 cycles |
| wait_n | input | 1 | Active-low stretch request from the flash |
| busy | output | 1 | A cycle is in progress |
| req_ack | output | 1 | One-cycle completion pulse |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_ce_n | output | 4 | Chip enables, one per bank, active low |
| nf_dq_out | output | 8 | Data bus output value |
| nf_dq_oe | output | 1 | Data bus output enable |
| nf_dq_in | input | 8 | Data bus input value |
| rd_byte | output | 8 | Byte captured by the last read |

## Verification
The assertions check on every cycle that the two strobes never overlap, that at most one chip enable is low and none is low while idle, that a strobe never rises unless wait_n was high at that edge, that the turnaround phase occurs only in writes, that the latched request stays fixed while busy, and that the acknowledge is a single pulse. The exact phase lengths depend on the field encodings: N+1 for setup, strobe and hold, exactly N for turnaround, and the max rule for read-after-latch delays. The bench scenarios measure these lengths at the pins. Only the scenarios also show the wait stretch length, the captured read byte, field values at 0 and 255, and the rule that a field changed in mid-cycle has no effect.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_ADDR  = 2'd1,
    K_READ  = 2'd2,
    K_WRITE = 2'd3
  } op_kind_t;

  typedef enum logic [2:0] {
    P_IDLE   = 3'd0,
    P_SETUP  = 3'd1,
    P_HIZ    = 3'd2,
    P_STROBE = 3'd3,
    P_HOLD   = 3'd4,
    P_ACK    = 3'd5
  } phase_t;

endpackage

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
  import nand_seq_pkg::*;
#(
  parameter int LONG_W  = 8,
  parameter int SHORT_W = 4,
  parameter int BANK_W  = 2,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  op_kind_t          req_kind,
  input  logic [DATA_W-1:0] req_byte,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [LONG_W-1:0] tim_setup,
  input  logic [LONG_W-1:0] tim_hiz,
  input  logic [LONG_W-1:0] tim_wait,
  input  logic [LONG_W-1:0] tim_hold,
  input  logic [SHORT_W-1:0] tim_cle_re,
  input  logic [SHORT_W-1:0] tim_ale_re,
  input  logic              wait_n,
  output phase_t            phase,
  output op_kind_t          cur_kind,
  output logic [BANK_W-1:0] cur_bank,
  output logic [DATA_W-1:0] cur_byte,
  output logic              accept_ev,
  output logic              strobe_end_ev
);

  // Count loaded for the setup phase: the phase lasts load+1 cycles.
  // A read straight after a latch cycle stretches setup to the latch-to-read delay.
  function automatic logic [LONG_W-1:0] setup_load(
    input op_kind_t            kind,
    input op_kind_t            prev,
    input logic [LONG_W-1:0]   su,
    input logic [SHORT_W-1:0]  cle_d,
    input logic [SHORT_W-1:0]  ale_d
  );
    logic [LONG_W-1:0] dly;
    dly = '0;
    if (kind == K_READ && prev == K_CMD)  dly = {{(LONG_W-SHORT_W){1'b0}}, cle_d};
    if (kind == K_READ && prev == K_ADDR) dly = {{(LONG_W-SHORT_W){1'b0}}, ale_d};
    return (dly > su) ? dly : su;
  endfunction

  logic [LONG_W-1:0] cnt;
  logic [LONG_W-1:0] t_hiz, t_wait, t_hold;
  op_kind_t          last_kind;
  logic              cnt_zero;

  assign cnt_zero      = (cnt == '0);
  assign accept_ev     = (phase == P_IDLE) && req_valid;
  assign strobe_end_ev = (phase == P_STROBE) && cnt_zero && wait_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= P_IDLE;
      cnt       <= '0;
      cur_kind  <= K_WRITE;
      cur_bank  <= '0;
      cur_byte  <= '0;
      t_hiz     <= '0;
      t_wait    <= '0;
      t_hold    <= '0;
      last_kind <= K_WRITE;
    end else begin
      unique case (phase)
        P_IDLE: if (accept_ev) begin
          phase    <= P_SETUP;
          cur_kind <= req_kind;
          cur_bank <= req_bank;
          cur_byte <= req_byte;
          t_hiz    <= tim_hiz;
          t_wait   <= tim_wait;
          t_hold   <= tim_hold;
          cnt      <= setup_load(req_kind, last_kind, tim_setup, tim_cle_re, tim_ale_re);
        end
        P_SETUP: if (!cnt_zero) cnt <= cnt - 1'b1;
          else if (cur_kind == K_WRITE && t_hiz != '0) begin
            phase <= P_HIZ;
            cnt   <= t_hiz - 1'b1;
          end else begin
            phase <= P_STROBE;
            cnt   <= t_wait;
          end
        P_HIZ: if (!cnt_zero) cnt <= cnt - 1'b1;
          else begin
            phase <= P_STROBE;
            cnt   <= t_wait;
          end
        P_STROBE: if (!cnt_zero) cnt <= cnt - 1'b1;
          else if (strobe_end_ev) begin
            phase <= P_HOLD;
            cnt   <= t_hold;
          end
        P_HOLD: if (!cnt_zero) cnt <= cnt - 1'b1;
          else begin
            phase     <= P_ACK;
            last_kind <= cur_kind;
          end
        P_ACK: phase <= P_IDLE;
        default: phase <= P_IDLE;
      endcase
    end
  end

  // R10: an accepted request always opens with the setup phase
  p_accept_setup_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (phase == P_SETUP));

  // R10: latched request stays fixed while a cycle runs
  p_latch_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != P_IDLE) |=> ($stable(cur_kind) && $stable(cur_byte) && $stable(cur_bank)));

  // R3: turnaround phase belongs to writes only
  p_hiz_write_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_HIZ) |-> (cur_kind == K_WRITE));

endmodule

// File: rtl/nand_bank_decode.sv
module nand_bank_decode #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] ce_n
);

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_ce
    assign ce_n[gi] = !(active && (bank == BANK_W'(gi)));
  end

  // R9: never more than one chip enabled
  p_ce_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n));

  // R9: no chip enabled outside a cycle
  p_ce_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (&ce_n));

endmodule

// File: rtl/nand_pin_drive.sv
module nand_pin_drive
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  op_kind_t          cur_kind,
  input  logic [DATA_W-1:0] cur_byte,
  input  logic              strobe_end_ev,
  input  logic [DATA_W-1:0] dq_in,
  output logic              active,
  output logic              cle,
  output logic              ale,
  output logic              re_n,
  output logic              we_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              ack,
  output logic [DATA_W-1:0] rd_byte
);

  logic in_strobe, drive_late;

  assign active     = (phase == P_SETUP) || (phase == P_HIZ) ||
                      (phase == P_STROBE) || (phase == P_HOLD);
  assign in_strobe  = (phase == P_STROBE);
  assign drive_late = in_strobe || (phase == P_HOLD);

  assign cle    = active && (cur_kind == K_CMD);
  assign ale    = active && (cur_kind == K_ADDR);
  assign re_n   = !(in_strobe && cur_kind == K_READ);
  assign we_n   = !(in_strobe && cur_kind != K_READ);
  assign dq_out = cur_byte;
  assign dq_oe  = ((cur_kind == K_CMD || cur_kind == K_ADDR) && active) ||
                  ((cur_kind == K_WRITE) && drive_late);
  assign ack    = (phase == P_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    rd_byte <= '0;
    else if (strobe_end_ev && cur_kind == K_READ)  rd_byte <= dq_in;
  end

  // R1: the two strobes never overlap
  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!re_n && !we_n));

  // R12: the block never drives the bus while reading
  p_no_drive_on_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 4,
  parameter int LONG_W    = 8,
  parameter int SHORT_W   = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_kind,
  input  logic [DATA_W-1:0]    req_byte,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [LONG_W-1:0]    tim_setup,
  input  logic [LONG_W-1:0]    tim_hiz,
  input  logic [LONG_W-1:0]    tim_wait,
  input  logic [LONG_W-1:0]    tim_hold,
  input  logic [SHORT_W-1:0]   tim_cle_re,
  input  logic [SHORT_W-1:0]   tim_ale_re,
  input  logic                 wait_n,
  output logic                 busy,
  output logic                 req_ack,
  output logic                 nf_cle,
  output logic                 nf_ale,
  output logic                 nf_re_n,
  output logic                 nf_we_n,
  output logic [NUM_BANKS-1:0] nf_ce_n,
  output logic [DATA_W-1:0]    nf_dq_out,
  output logic                 nf_dq_oe,
  input  logic [DATA_W-1:0]    nf_dq_in,
  output logic [DATA_W-1:0]    rd_byte
);

  phase_t            phase;
  op_kind_t          cur_kind;
  logic [BANK_W-1:0] cur_bank;
  logic [DATA_W-1:0] cur_byte;
  logic              accept_ev, strobe_end_ev, active;

  nand_phase_fsm #(
    .LONG_W(LONG_W), .SHORT_W(SHORT_W), .BANK_W(BANK_W), .DATA_W(DATA_W)
  ) fsm_i (
    .clk, .rst_n, .req_valid,
    .req_kind(op_kind_t'(req_kind)),
    .req_byte, .req_bank,
    .tim_setup, .tim_hiz, .tim_wait, .tim_hold, .tim_cle_re, .tim_ale_re,
    .wait_n,
    .phase, .cur_kind, .cur_bank, .cur_byte, .accept_ev, .strobe_end_ev
  );

  nand_pin_drive #(.DATA_W(DATA_W)) pins_i (
    .clk, .rst_n, .phase, .cur_kind, .cur_byte, .strobe_end_ev,
    .dq_in(nf_dq_in), .active,
    .cle(nf_cle), .ale(nf_ale), .re_n(nf_re_n), .we_n(nf_we_n),
    .dq_out(nf_dq_out), .dq_oe(nf_dq_oe), .ack(req_ack), .rd_byte
  );

  nand_bank_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) bank_i (
    .clk, .rst_n, .active, .bank(cur_bank), .ce_n(nf_ce_n)
  );

  assign busy = (phase != P_IDLE);

  // R5: a strobe only rises after an edge at which wait_n was high
  p_strobe_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_re_n & nf_we_n) |-> $past(wait_n));

  // R6: acknowledge is a single pulse that ends the cycle
  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> (!req_ack && !busy));

endmodule

// File: tb/nand_cycle_seq_tb_top.sv
module nand_cycle_seq_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, req_valid, wait_n;
  logic [1:0] req_kind, req_bank;
  logic [7:0] req_byte, tim_setup, tim_hiz, tim_wait, tim_hold, nf_dq_in;
  logic [3:0] tim_cle_re, tim_ale_re;
  logic       busy, req_ack, nf_cle, nf_ale, nf_re_n, nf_we_n, nf_dq_oe;
  logic [3:0] nf_ce_n;
  logic [7:0] nf_dq_out, rd_byte;

  nand_cycle_seq dut_i (
    .clk, .rst_n, .req_valid, .req_kind, .req_byte, .req_bank,
    .tim_setup, .tim_hiz, .tim_wait, .tim_hold, .tim_cle_re, .tim_ale_re,
    .wait_n, .busy, .req_ack, .nf_cle, .nf_ale, .nf_re_n, .nf_we_n,
    .nf_ce_n, .nf_dq_out, .nf_dq_oe, .nf_dq_in, .rd_byte
  );

  int n_checks = 0;
  int n_fail   = 0;
  int last_kind = 3;  // bench's own record of the previous cycle kind

  // measurements of the most recent cycle
  int m_pre, m_pre_oe, m_strobe, m_post, m_ce_bad, m_ctl_bad, m_stb_bad, m_data_bad;
  int m_idle_busy, m_idle_ce;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected setup+turnaround cycles before the strobe falls
  function automatic int exp_pre(input int kind, input int prev);
    int base;
    base = tim_setup;
    if (kind == 2 && prev == 0) base = imax(tim_setup, tim_cle_re);
    if (kind == 2 && prev == 1) base = imax(tim_setup, tim_ale_re);
    return base + 1 + ((kind == 3) ? int'(tim_hiz) : 0);
  endfunction

  task automatic do_cycle(input logic [1:0] kind, input logic [7:0] b,
                          input logic [1:0] bank, input int wait_k, input bit disturb);
    bit seen = 0;
    bit done = 0;
    int guard = 0;
    bit stb;
    m_pre = 0; m_pre_oe = 0; m_strobe = 0; m_post = 0;
    m_ce_bad = 0; m_ctl_bad = 0; m_stb_bad = 0; m_data_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_byte = b; req_bank = bank;
    wait_n = (wait_k > 0) ? 1'b0 : 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (disturb) begin
      req_valid = 1'b1; req_kind = 2'd2; req_byte = ~b; req_bank = bank + 2'd1;
      tim_setup = 8'd40; tim_hiz = 8'd40; tim_wait = 8'd40; tim_hold = 8'd40;
    end
    while (!done && guard < 4000) begin
      guard++;
      if (req_ack) begin
        done = 1;
        req_valid = 1'b0;
      end else begin
        if (nf_ce_n != ~(4'b0001 << bank)) m_ce_bad++;
        if (nf_cle != (kind == 2'd0) || nf_ale != (kind == 2'd1)) m_ctl_bad++;
        stb = (kind == 2'd2) ? !nf_re_n : !nf_we_n;
        if ((kind == 2'd2) ? !nf_we_n : !nf_re_n) m_stb_bad++;
        if (nf_dq_oe && nf_dq_out != b) m_data_bad++;
        if (stb) begin
          seen = 1;
          m_strobe++;
          if (m_strobe == wait_k) wait_n = 1'b1;
        end else if (!seen) begin
          m_pre++;
          if (nf_dq_oe) m_pre_oe++;
        end else begin
          m_post++;
          if (kind != 2'd2 && !nf_dq_oe) m_data_bad++;
        end
        @(negedge clk);
      end
    end
    wait_n = 1'b1;
    @(negedge clk);
    m_idle_busy = busy;
    m_idle_ce   = nf_ce_n;
    last_kind   = kind;
  endtask

  task automatic set_tim(input int su, input int hz, input int wt, input int hd,
                         input int cr, input int ar);
    tim_setup = 8'(su); tim_hiz = 8'(hz); tim_wait = 8'(wt); tim_hold = 8'(hd);
    tim_cle_re = 4'(cr); tim_ale_re = 4'(ar);
  endtask

  task automatic t_reset;
    check(busy == 0 && req_ack == 0, "R11 busy/ack after reset", {busy, req_ack}, 0);
    check(nf_cle == 0 && nf_ale == 0 && nf_dq_oe == 0, "R11 cle/ale/oe after reset",
          {nf_cle, nf_ale, nf_dq_oe}, 0);
    check(nf_re_n && nf_we_n && nf_ce_n == 4'hF, "R11 strobes and CE_n after reset",
          {nf_re_n, nf_we_n, nf_ce_n}, 63);
    check(rd_byte == 0, "R11 rd_byte after reset", rd_byte, 0);
  endtask

  task automatic t_command;
    int ep;
    set_tim(2, 0, 3, 1, 0, 0);
    ep = exp_pre(0, last_kind);
    do_cycle(2'd0, 8'hA5, 2'd2, 0, 0);
    check(m_pre == ep, "R2 command setup cycles", m_pre, ep);
    check(m_pre_oe == ep, "R12 command drives bus from setup", m_pre_oe, ep);
    check(m_strobe == 4, "R4 command strobe cycles", m_strobe, 4);
    check(m_post == 2, "R6 command hold cycles", m_post, 2);
    check(m_ctl_bad == 0 && m_stb_bad == 0, "R1 command CLE/WE_n", m_ctl_bad + m_stb_bad, 0);
    check(m_ce_bad == 0, "R9 bank 2 chip enable", m_ce_bad, 0);
    check(m_data_bad == 0, "R12 command byte on bus", m_data_bad, 0);
    check(m_idle_busy == 0 && m_idle_ce == 15, "R6 idle after ack", m_idle_busy, 0);
  endtask

  task automatic t_address;
    set_tim(0, 5, 0, 0, 0, 0);
    do_cycle(2'd1, 8'h3C, 2'd1, 0, 0);
    check(m_pre == 1, "R3 address ignores hiz field", m_pre, 1);
    check(m_strobe == 1, "R4 address strobe minimum", m_strobe, 1);
    check(m_post == 1, "R6 address hold minimum", m_post, 1);
    check(m_ctl_bad == 0 && m_stb_bad == 0, "R1 address ALE/WE_n", m_ctl_bad + m_stb_bad, 0);
    check(m_ce_bad == 0, "R9 bank 1 chip enable", m_ce_bad, 0);
  endtask

  task automatic t_write;
    set_tim(1, 3, 2, 4, 0, 0);
    do_cycle(2'd3, 8'h5A, 2'd3, 0, 0);
    check(m_pre == 5, "R3 write setup plus turnaround", m_pre, 5);
    check(m_pre_oe == 0, "R3 bus released in setup and turnaround", m_pre_oe, 0);
    check(m_strobe == 3 && m_post == 5, "R4 write strobe/hold", m_strobe * 100 + m_post, 305);
    check(m_data_bad == 0 && m_stb_bad == 0, "R12 write data held", m_data_bad + m_stb_bad, 0);
    set_tim(1, 0, 0, 0, 0, 0);
    do_cycle(2'd3, 8'h11, 2'd0, 0, 0);
    check(m_pre == 2, "R3 zero turnaround adds nothing", m_pre, 2);
  endtask

  task automatic t_read_delays;
    int ep;
    set_tim(0, 0, 0, 0, 0, 0);
    do_cycle(2'd0, 8'h00, 2'd0, 0, 0);
    set_tim(1, 7, 1, 0, 9, 2);
    nf_dq_in = 8'hC3;
    ep = exp_pre(2, last_kind);
    do_cycle(2'd2, 8'h00, 2'd0, 0, 0);
    check(m_pre == ep && ep == 10, "R7 read after command uses cle_re", m_pre, ep);
    check(m_stb_bad == 0 && m_ctl_bad == 0 && m_pre_oe == 0, "R1 read uses RE_n only",
          m_stb_bad + m_ctl_bad + m_pre_oe, 0);
    check(rd_byte == 8'hC3, "R8 read byte captured", rd_byte, 8'hC3);
    nf_dq_in = 8'h96;
    do_cycle(2'd2, 8'h00, 2'd0, 0, 0);
    check(m_pre == 2, "R7 read after read uses setup", m_pre, 2);
    check(rd_byte == 8'h96, "R8 second read byte", rd_byte, 8'h96);
    set_tim(0, 0, 0, 0, 0, 6);
    do_cycle(2'd1, 8'h10, 2'd0, 0, 0);
    nf_dq_in = 8'h5F;
    do_cycle(2'd2, 8'h00, 2'd0, 0, 0);
    check(m_pre == 7, "R7 read after address uses ale_re", m_pre, 7);
    nf_dq_in = 8'h00;
    set_tim(12, 0, 0, 0, 3, 0);
    do_cycle(2'd0, 8'h22, 2'd0, 0, 0);
    do_cycle(2'd2, 8'h00, 2'd0, 0, 0);
    check(m_pre == 13, "R7 larger setup wins over cle_re", m_pre, 13);
    nf_dq_in = 8'hEE;
    do_cycle(2'd3, 8'h77, 2'd0, 0, 0);
    check(rd_byte == 8'h00, "R8 rd_byte held across a write", rd_byte, 0);
  endtask

  task automatic t_wait_stretch;
    set_tim(0, 0, 1, 0, 0, 0);
    do_cycle(2'd3, 8'h44, 2'd1, 5, 0);
    check(m_strobe == 5, "R5 wait_n low stretches strobe", m_strobe, 5);
    set_tim(0, 0, 3, 0, 0, 0);
    do_cycle(2'd2, 8'h00, 2'd1, 2, 0);
    check(m_strobe == 4, "R5 short wait inside programmed count", m_strobe, 4);
  endtask

  task automatic t_disturb;
    int quiet = 0;
    set_tim(1, 0, 2, 1, 0, 0);
    do_cycle(2'd0, 8'h81, 2'd2, 0, 1);
    check(m_pre == 2 && m_strobe == 3 && m_post == 2, "R10 fields fixed at accept",
          m_pre * 100 + m_strobe * 10 + m_post, 232);
    check(m_ce_bad == 0 && m_data_bad == 0 && m_ctl_bad == 0, "R10 request fixed at accept",
          m_ce_bad + m_data_bad + m_ctl_bad, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy || !nf_re_n || !nf_we_n) quiet++;
    end
    check(quiet == 0 && m_idle_busy == 0, "R10 request during busy not taken", quiet, 0);
  endtask

  task automatic t_long;
    set_tim(255, 0, 255, 255, 0, 0);
    do_cycle(2'd0, 8'hFF, 2'd3, 0, 0);
    check(m_pre == 256, "R2 setup field 255", m_pre, 256);
    check(m_strobe == 256, "R4 strobe field 255", m_strobe, 256);
    check(m_post == 256, "R6 hold field 255", m_post, 256);
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; wait_n = 1'b1;
    req_kind = '0; req_byte = '0; req_bank = '0; nf_dq_in = '0;
    set_tim(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_command();
    t_address();
    t_write();
    t_read_delays();
    t_wait_stretch();
    t_disturb();
    t_long();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule